// File: doc/BRIEF.md
# Pipeline Hazard and Branch Bypass Controller

This controller manages data hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose conditional branches test one register for zero and resolve in the decode stage. Each cycle it looks at the decoded instruction's source registers, operand-use flags and branch flags. It compares them with the destination, write enable and load flag of the instructions now in execute and memory. From this it decides whether decode must wait. A stall holds the program counter and the fetch/decode register, and a bubble goes into execute.

The controller also picks where the branch comparator gets its operand: the register file, the execute result or the memory-stage result. For the instruction leaving decode, it registers the operand sources the execute stage will use one cycle later. The comparator returns a zero flag. When a branch is taken and not stalled, the controller raises a redirect strobe, which loads the target into the program counter at the end of that cycle. Depending on a parameter, the instruction fetched behind a taken branch is either squashed or kept as a delay slot that always runs. The register file writes before it reads, so a producer in writeback needs no action here.

Top module: `hz_ctrl`

## Requirements
- R1: While rst_ni is low, and at the first sample after release, both execute operand selects read 0 (register file).
- R2: A producer with write enable clear, or one whose destination is register 0, never causes a stall and never selects a bypass.
- R3: A branch whose producer has already left the memory stage (so execute and memory hold no match) proceeds without a stall, and br_fwd_o is 0 (register file).
- R4: A branch whose nearest producer is a non-load in memory does not stall and gets br_fwd_o = 2 (memory result).
- R5: A branch whose producer is a non-load in execute gets br_fwd_o = 1 (execute result) with no stall when EX_BYPASS = 1. When EX_BYPASS = 0 it stalls.
- R6: A branch whose nearest producer is a load stalls, whether that load is in execute or in memory.
- R7: An instruction that uses a source register (use flag set) written by a load now in execute stalls. A matching register whose use flag is clear causes no stall.
- R8: One cycle after an instruction leaves decode, each execute operand select reads 1 when the producer was in execute, 2 when it was in memory, and 0 otherwise. Execute has priority over memory.
- R9: For the branch operand, a producer in execute takes priority over one in memory.
- R10: After a stall cycle, both execute operand selects read 0 (bubble).
- R11: redirect_o is high when a valid, unstalled branch is taken. A branch-if-zero (id_br_ne_i = 0) is taken when br_zero_i = 1. A branch-if-nonzero (id_br_ne_i = 1) is taken when br_zero_i = 0. A stalled branch never redirects.
- R12: With DELAY_SLOT = 0, squash_o equals redirect_o. With DELAY_SLOT = 1, squash_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_rs1_i | input | AW | First source register (branch condition register) |
| id_rs2_i | input | AW | Second source register |
| id_use_rs1_i | input | 1 | ALU reads the first source |
| id_use_rs2_i | input | 1 | ALU reads the second source |
| id_is_br_i | input | 1 | Decode holds a conditional branch |
| id_br_ne_i | input | 1 | 1 = branch if nonzero, 0 = branch if zero |
| br_zero_i | input | 1 | Comparator: the selected operand is zero |
| ex_rd_i | input | AW | Execute-stage destination |
| ex_we_i | input | 1 | Execute-stage write enable |
| ex_ld_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | AW | Memory-stage destination |
| mem_we_i | input | 1 | Memory-stage write enable |
| mem_ld_i | input | 1 | Memory-stage instruction is a load |
| stall_o | output | 1 | Hold PC and fetch/decode, bubble into execute |
| br_fwd_o | output | 2 | Branch operand source: 0 register file, 1 execute, 2 memory |
| ex_fwd_a_o | output | 2 | Execute operand A source: 0 register file, 1 memory, 2 writeback |
| ex_fwd_b_o | output | 2 | Execute operand B source: 0 register file, 1 memory, 2 writeback |
| redirect_o | output | 1 | Load branch target into PC |
| squash_o | output | 1 | Turn the fetched instruction into a bubble |

## Verification
The bench targets a branch that follows a load, where the value is not ready until writeback. A design that forwarded from memory here would hand the comparator an address instead of data. It also aims at producers of register 0 and at producers with write enable clear; a design that got these wrong would stall for no reason or select a stale bypass. Execute and memory are made to write the same register, so that picking the older producer shows up as a wrong select. The bench also puts a taken branch on a stall cycle: a design that redirected early would fetch the target before the condition is valid. A second instance with the alternate parameters exposes any mix-up between squash mode and delay-slot mode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BR_SRC_RF  = 2'd0,
    BR_SRC_EX  = 2'd1,
    BR_SRC_MEM = 2'd2
  } br_src_e;

  typedef enum logic [1:0] {
    OP_SRC_RF  = 2'd0,
    OP_SRC_MEM = 2'd1,
    OP_SRC_WB  = 2'd2
  } op_src_e;
endpackage

// File: rtl/hz_prod_match.sv
module hz_prod_match #(
  parameter int unsigned AW = 5,
  parameter int unsigned NP = 2
) (
  input  logic [AW-1:0]    src_i,
  input  logic [NP*AW-1:0] rd_i,
  input  logic [NP-1:0]    we_i,
  output logic [NP-1:0]    hit_o
);
  // bit 0 is the youngest producer
  for (genvar gi = 0; gi < NP; gi++) begin : g_stage
    assign hit_o[gi] = we_i[gi] && (src_i != '0) && (rd_i[gi*AW +: AW] == src_i);
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned NOPS = 2
) (
  input  logic            valid_i,
  input  logic [NOPS-1:0] use_i,
  input  logic [NOPS-1:0] ex_hit_i,
  input  logic            ex_ld_i,
  output logic            stall_o
);
  assign stall_o = valid_i && ex_ld_i && |(use_i & ex_hit_i);
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
  import hz_pkg::*;
#(
  parameter bit EX_BYPASS = 1'b1
) (
  input  logic       valid_i,
  input  logic       is_br_i,
  input  logic [1:0] hit_i,    // [0] execute, [1] memory
  input  logic       ex_ld_i,
  input  logic       mem_ld_i,
  output logic       stall_o,
  output logic [1:0] src_o
);
  br_src_e src;

  always_comb begin
    src     = BR_SRC_RF;
    stall_o = 1'b0;
    if (valid_i && is_br_i) begin
      if (hit_i[0]) begin
        if (EX_BYPASS && !ex_ld_i) src = BR_SRC_EX;
        else                       stall_o = 1'b1;
      end else if (hit_i[1]) begin
        // loaded data only reaches ID via the write-first register file
        if (!mem_ld_i) src = BR_SRC_MEM;
        else           stall_o = 1'b1;
      end
    end
  end

  assign src_o = src;
endmodule

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import hz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       use_i,
  input  logic       stall_i,
  input  logic [1:0] hit_i,   // [0] execute, [1] memory
  output logic [1:0] sel_o
);
  op_src_e sel_q;

  // producers advance one stage as the consumer enters execute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sel_q <= OP_SRC_RF;
    else if (stall_i || !valid_i || !use_i) sel_q <= OP_SRC_RF;
    else if (hit_i[0])                    sel_q <= OP_SRC_MEM;
    else if (hit_i[1])                    sel_q <= OP_SRC_WB;
    else                                  sel_q <= OP_SRC_RF;
  end

  assign sel_o = sel_q;

  a_r10_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> sel_o == OP_SRC_RF);
  a_r8_ex_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && use_i && !stall_i && hit_i[0]) |=> sel_o == OP_SRC_MEM);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned AW         = 5,
  parameter bit          EX_BYPASS  = 1'b1,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_valid_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use_rs1_i,
  input  logic          id_use_rs2_i,
  input  logic          id_is_br_i,
  input  logic          id_br_ne_i,
  input  logic          br_zero_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_ld_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic          mem_ld_i,
  output logic          stall_o,
  output logic [1:0]    br_fwd_o,
  output logic [1:0]    ex_fwd_a_o,
  output logic [1:0]    ex_fwd_b_o,
  output logic          redirect_o,
  output logic          squash_o
);
  localparam int unsigned NPROD = 2;
  localparam int unsigned NOPS  = 2;

  logic [NPROD*AW-1:0] prod_rd;
  logic [NPROD-1:0]    prod_we;
  logic [AW-1:0]       op_src [NOPS];
  logic [NOPS-1:0]     op_use;
  logic [NPROD-1:0]    op_hit [NOPS];
  logic [1:0]          op_sel [NOPS];
  logic [NOPS-1:0]     ex_hit;
  logic                lu_stall, br_stall, stall, taken;

  assign prod_rd   = {mem_rd_i, ex_rd_i};
  assign prod_we   = {mem_we_i, ex_we_i};
  assign op_src[0] = id_rs1_i;
  assign op_src[1] = id_rs2_i;
  assign op_use    = {id_use_rs2_i, id_use_rs1_i};

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_op
    hz_prod_match #(.AW(AW), .NP(NPROD)) u_match (
      .src_i (op_src[gi]),
      .rd_i  (prod_rd),
      .we_i  (prod_we),
      .hit_o (op_hit[gi])
    );
    hz_ex_fwd u_fwd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (id_valid_i),
      .use_i   (op_use[gi]),
      .stall_i (stall),
      .hit_i   (op_hit[gi]),
      .sel_o   (op_sel[gi])
    );
    assign ex_hit[gi] = op_hit[gi][0];
  end

  hz_load_use #(.NOPS(NOPS)) u_lu (
    .valid_i  (id_valid_i),
    .use_i    (op_use),
    .ex_hit_i (ex_hit),
    .ex_ld_i  (ex_ld_i),
    .stall_o  (lu_stall)
  );

  hz_branch_unit #(.EX_BYPASS(EX_BYPASS)) u_br (
    .valid_i  (id_valid_i),
    .is_br_i  (id_is_br_i),
    .hit_i    (op_hit[0]),
    .ex_ld_i  (ex_ld_i),
    .mem_ld_i (mem_ld_i),
    .stall_o  (br_stall),
    .src_o    (br_fwd_o)
  );

  assign stall      = lu_stall | br_stall;
  assign taken      = id_valid_i && id_is_br_i && (id_br_ne_i ^ br_zero_i);
  assign stall_o    = stall;
  assign redirect_o = taken && !stall;
  assign ex_fwd_a_o = op_sel[0];
  assign ex_fwd_b_o = op_sel[1];

  if (DELAY_SLOT) begin : g_delay
    assign squash_o = 1'b0;
  end else begin : g_squash
    assign squash_o = redirect_o;
  end

  a_r7_load_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && ex_we_i && ex_ld_i && ex_rd_i != '0 && id_use_rs2_i && id_rs2_i == ex_rd_i)
      |-> stall_o);
  a_r6_branch_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && id_is_br_i && ex_we_i && ex_ld_i && ex_rd_i != '0 && id_rs1_i == ex_rd_i)
      |-> stall_o);
  a_r11_no_early_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !redirect_o);
  a_r12_squash_only_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> redirect_o);
  a_r2_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0) |-> br_fwd_o == BR_SRC_RF);
endmodule

// File: tb/sim_hz_ctrl.sv
module sim_hz_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          v, u1, u2, br, ne, z, exwe, exld, mwe, mld;
  logic [AW-1:0] rs1, rs2, exrd, mrd;

  logic       st0, rd0, sq0, st1, rd1, sq1;
  logic [1:0] bf0, fa0, fb0, bf1, fa1, fb1;

  hz_ctrl #(.AW(AW), .EX_BYPASS(1'b1), .DELAY_SLOT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .id_valid_i(v), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_use_rs1_i(u1), .id_use_rs2_i(u2), .id_is_br_i(br), .id_br_ne_i(ne), .br_zero_i(z),
    .ex_rd_i(exrd), .ex_we_i(exwe), .ex_ld_i(exld), .mem_rd_i(mrd), .mem_we_i(mwe),
    .mem_ld_i(mld), .stall_o(st0), .br_fwd_o(bf0), .ex_fwd_a_o(fa0), .ex_fwd_b_o(fb0),
    .redirect_o(rd0), .squash_o(sq0));

  hz_ctrl #(.AW(AW), .EX_BYPASS(1'b0), .DELAY_SLOT(1'b1)) u1i (
    .clk_i(clk), .rst_ni(rst_ni), .id_valid_i(v), .id_rs1_i(rs1), .id_rs2_i(rs2),
    .id_use_rs1_i(u1), .id_use_rs2_i(u2), .id_is_br_i(br), .id_br_ne_i(ne), .br_zero_i(z),
    .ex_rd_i(exrd), .ex_we_i(exwe), .ex_ld_i(exld), .mem_rd_i(mrd), .mem_we_i(mwe),
    .mem_ld_i(mld), .stall_o(st1), .br_fwd_o(bf1), .ex_fwd_a_o(fa1), .ex_fwd_b_o(fb1),
    .redirect_o(rd1), .squash_o(sq1));

  int n_run = 0, n_fail = 0;
  int ea[2], eb[2], na[2], nb[2];

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference for one configuration
  task automatic model(input bit byp, input bit ds, output int s, output int b,
                       output int r, output int q, output int a, output int c);
    int prod;   // stage holding nearest writer of rs1 for the branch: 0 none, 1 EX, 2 MEM
    bit lu;
    s = 0; b = 0; prod = 0;
    if (exwe && exrd != 0 && exrd == rs1) prod = 1;
    else if (mwe && mrd != 0 && mrd == rs1) prod = 2;
    if (v && br) begin
      if (prod == 1) begin if (!byp || exld) s = 1; else b = 1; end
      if (prod == 2) begin if (mld) s = 1; else b = 2; end
    end
    lu = v && exwe && exld && exrd != 0 &&
         ((u1 && rs1 == exrd) || (u2 && rs2 == exrd));
    if (lu) s = 1;
    r = (v && br && s == 0 && ((ne && !z) || (!ne && z))) ? 1 : 0;
    q = ds ? 0 : r;
    a = 0; c = 0;
    if (v && s == 0) begin
      if (u1 && rs1 != 0) a = (exwe && exrd == rs1) ? 1 : (mwe && mrd == rs1) ? 2 : 0;
      if (u2 && rs2 != 0) c = (exwe && exrd == rs2) ? 1 : (mwe && mrd == rs2) ? 2 : 0;
    end
  endtask

  task automatic cyc(string tag);
    int s, b, r, q;
    string t;
    @(negedge clk);
    t = (tag == "") ? "R8" : tag;
    chk(t, "u0 fwd_a", fa0, ea[0]); chk(t, "u0 fwd_b", fb0, eb[0]);
    chk(t, "u1 fwd_a", fa1, ea[1]); chk(t, "u1 fwd_b", fb1, eb[1]);
    #2;
    model(1'b1, 1'b0, s, b, r, q, na[0], nb[0]);
    chk(tag == "" ? "R7" : tag, "u0 stall", st0, s);
    chk(tag == "" ? "R9" : tag, "u0 br_fwd", bf0, b);
    chk(tag == "" ? "R11" : tag, "u0 redirect", rd0, r);
    chk(tag == "" ? "R12" : tag, "u0 squash", sq0, q);
    model(1'b0, 1'b1, s, b, r, q, na[1], nb[1]);
    chk(tag == "" ? "R5" : tag, "u1 stall", st1, s);
    chk(tag == "" ? "R9" : tag, "u1 br_fwd", bf1, b);
    chk(tag == "" ? "R11" : tag, "u1 redirect", rd1, r);
    chk(tag == "" ? "R12" : tag, "u1 squash", sq1, q);
    @(posedge clk); #1;
    for (int k = 0; k < 2; k++) begin ea[k] = na[k]; eb[k] = nb[k]; end
  endtask

  task automatic idle();
    v = 1; u1 = 0; u2 = 0; br = 0; ne = 0; z = 0;
    rs1 = 0; rs2 = 0; exrd = 0; exwe = 0; exld = 0; mrd = 0; mwe = 0; mld = 0;
  endtask

  task automatic brn(int r, bit n, bit zz);
    idle(); br = 1; rs1 = AW'(r); ne = n; z = zz;
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(); exwe = 1; exrd = 3; u1 = 1; rs1 = 3;
    for (int k = 0; k < 2; k++) begin ea[k] = 0; eb[k] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "u0 fwd_a rst", fa0, 0); chk("R1", "u0 fwd_b rst", fb0, 0);
    chk("R1", "u1 fwd_a rst", fa1, 0);
    rst_ni = 1;
    idle();
    cyc("R1");
    // R5: ALU producer in EX feeds the branch
    brn(3, 0, 1); exwe = 1; exrd = 3; cyc("R5");
    // R6: load in EX, then in MEM
    brn(3, 0, 1); exwe = 1; exld = 1; exrd = 3; cyc("R6");
    brn(3, 0, 1); mwe = 1; mld = 1; mrd = 3; cyc("R6");
    // R3: the load has moved past MEM
    brn(3, 0, 1); cyc("R3");
    // R4: ALU producer in MEM
    brn(3, 1, 0); mwe = 1; mrd = 3; cyc("R4");
    // R9: EX and MEM both write the branch register
    brn(3, 1, 0); exwe = 1; exrd = 3; mwe = 1; mrd = 3; cyc("R9");
    // R2: register 0 and cleared write enable
    brn(0, 0, 1); exwe = 1; exld = 1; exrd = 0; cyc("R2");
    brn(2, 0, 1); exwe = 0; exld = 1; exrd = 2; mwe = 0; mrd = 2; cyc("R2");
    idle(); u1 = 1; rs1 = 0; exwe = 1; exld = 1; exrd = 0; cyc("R2");
    cyc("R2");
    // R7: load-use on rs2, and unused matching register
    idle(); u2 = 1; rs2 = 4; exwe = 1; exld = 1; exrd = 4; cyc("R7");
    // R10: selects after the stall
    idle(); cyc("R10");
    idle(); u2 = 0; rs2 = 4; exwe = 1; exld = 1; exrd = 4; cyc("R7");
    // R8: EX, MEM and overlapping producers
    idle(); u1 = 1; rs1 = 5; exwe = 1; exrd = 5; u2 = 1; rs2 = 6; mwe = 1; mrd = 6; cyc("R8");
    idle(); u1 = 1; rs1 = 7; exwe = 1; exrd = 7; mwe = 1; mrd = 7; cyc("R8");
    idle(); cyc("R8");
    // R11/R12: taken and not-taken branches
    brn(1, 0, 1); cyc("R11");
    brn(1, 0, 0); cyc("R11");
    brn(1, 1, 0); cyc("R12");
    brn(1, 1, 1); cyc("R12");
    brn(1, 1, 0); exwe = 1; exld = 1; exrd = 1; cyc("R11");
    // random mix with small register space
    for (int i = 0; i < 3000; i++) begin
      v = ($urandom_range(9) != 0); u1 = 1'($urandom); u2 = 1'($urandom);
      br = 1'($urandom); ne = 1'($urandom); z = 1'($urandom);
      rs1 = AW'($urandom_range(3)); rs2 = AW'($urandom_range(3));
      exrd = AW'($urandom_range(3)); exwe = 1'($urandom); exld = 1'($urandom);
      mrd = AW'($urandom_range(3)); mwe = 1'($urandom); mld = 1'($urandom);
      cyc("");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule